// File: doc/BRIEF.md
# Flag-Tagged Serial Receiver with 64-Entry Queue

This block turns an asynchronous serial input into 8-bit characters and queues them for a host. The line is first passed through a synchronizer. It is then sampled at sixteen times the bit rate. That rate comes from the system clock divided by a 10-bit divisor. A received character can carry an optional even parity bit and one or two stop bits.

Each queued character keeps its own error flags for break, framing, parity and overrun. A host that drains the queue therefore sees which character went wrong, not just that something did. The host reads through a first-word-fall-through port: the oldest entry is always visible on the read word, and a one-cycle read strobe removes it. Four status outputs report the queue level: data ready, empty, full and half full. A clear input empties the queue at once.

Top module: `uart_rx_tagged`

## Requirements
- R1: The sampling tick runs at the clock rate divided by the divisor input, and one bit time is 16 ticks. A divisor of 0 or 1 stops the tick, so nothing is received.
- R2: A frame is one low start bit followed by 8 data bits sent least significant bit first. The data byte appears in bits 7:0 of the read word, and bits 11:8 are always zero.
- R3: A start bit counts only if the line is still low at the eighth tick after the falling edge is seen. A shorter low pulse is discarded and produces no entry.
- R4: When parity is enabled, one even-parity bit follows the data. A mismatch sets bit 13 of that character's word. When parity is disabled, no parity bit is expected and bit 13 stays clear.
- R5: A stop bit sampled low sets the framing flag, bit 14. With two stop bits selected, a low second stop bit also sets it.
- R6: If every sampled bit is low, including the data bits, the parity bit when enabled, and the first stop bit, the entry is 0x00 with bits 15 and 14 both set. After such an entry, no new start is accepted until the line has returned high.
- R7: A character that completes while the queue is full is dropped. The next character that is stored gets its overrun flag, bit 12, set.
- R8: The queue holds 64 entries and returns them in arrival order. Empty is high at 0 entries, full at 64, and half full at 32 or more. Ready is high whenever the queue is not empty.
- R9: The read word shows the oldest entry while the queue is not empty and reads zero when it is empty. A read strobe removes one entry at the clock edge. A read strobe on an empty queue has no effect.
- R10: The clear input empties the queue at the next clock edge and also cancels a pending overrun flag. Normal operation returns once the input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| baud_div | input | 10 | Clock cycles per sampling tick |
| par_even_en | input | 1 | Expect an even parity bit after the data |
| stop_two | input | 1 | Expect two stop bits |
| q_clear | input | 1 | Empty the queue and cancel a pending overrun |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_word | output | 16 | Oldest entry: data in 7:0, flags in 15:12 |
| rx_ready | output | 1 | At least one entry is waiting |
| q_empty | output | 1 | Queue holds no entries |
| q_full | output | 1 | Queue holds 64 entries |
| q_half | output | 1 | Queue holds 32 or more entries |

## Verification
The overrun marking is the hardest case to reach from the ports. The queue must first hold all 64 entries. Further characters must then arrive and be dropped. Only after that does a read free a slot, so that a fresh character can show the flag. The stimulus uses the smallest legal divisor to fill the queue quickly, sends two extra frames into the full queue, and pops once before the next frame. A second fill followed by a clear checks that a pending overrun does not survive the clear. Break, glitch and stopped-tick cases are driven as shaped line waveforms, and the queue state is compared against a reference model every clock.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic       ovr;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_STOP2,
        RX_HOLD
    } rx_state_e;

    function automatic logic [15:0] entry_to_word(input rx_entry_t e);
        return {e.brk, e.frm, e.par, e.ovr, 4'b0000, e.data};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             div_ok;

    always_comb begin
        div_ok = (div_i >= DIV_W'(2));
        tick_o = div_ok && (cnt_q >= div_i - DIV_W'(1));
        if (!div_ok || tick_o) cnt_d = '0;
        else                   cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a legal divisor never yields ticks on back-to-back cycles
    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i >= DIV_W'(2) && $stable(div_i)) |=> !tick_o);

    // R1: an illegal divisor holds the counter at rest
    assert_tick_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i < DIV_W'(2)) |=> (cnt_q == '0));
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic      par_en_i,
    input  logic      two_stop_i,
    output logic      vld_o,
    output rx_entry_t ent_o
);
    localparam int PH_W  = $clog2(OVS);
    localparam int MID   = OVS / 2 - 1;
    localparam int BIT_W = $clog2(DATA_BITS + 1);

    typedef struct packed {
        rx_state_e            st;
        logic [PH_W-1:0]      ph;
        logic [BIT_W-1:0]     nbit;
        logic [DATA_BITS-1:0] sh;
        logic                 perr;
        logic                 all_low;
        logic                 frm;
        logic                 brk;
        logic                 vld;
    } fr_state_t;

    fr_state_t s_d, s_q;
    logic      bit_end;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        bit_end = (s_q.ph == PH_W'(OVS - 1));
        if (tick_i) begin
            unique case (s_q.st)
                RX_IDLE: begin
                    if (!rx_i) begin
                        s_d.st = RX_START;
                        s_d.ph = '0;
                    end
                end
                RX_START: begin
                    if (s_q.ph == PH_W'(MID)) begin
                        s_d.ph = '0;
                        if (!rx_i) begin
                            s_d.st      = RX_DATA;
                            s_d.nbit    = '0;
                            s_d.all_low = 1'b1;
                            s_d.perr    = 1'b0;
                            s_d.frm     = 1'b0;
                            s_d.brk     = 1'b0;
                        end else begin
                            s_d.st = RX_IDLE;
                        end
                    end else begin
                        s_d.ph = s_q.ph + PH_W'(1);
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        s_d.ph      = '0;
                        s_d.sh      = {rx_i, s_q.sh[DATA_BITS-1:1]};
                        s_d.all_low = s_q.all_low & ~rx_i;
                        if (s_q.nbit == BIT_W'(DATA_BITS - 1))
                            s_d.st = par_en_i ? RX_PARITY : RX_STOP;
                        else
                            s_d.nbit = s_q.nbit + BIT_W'(1);
                    end else begin
                        s_d.ph = s_q.ph + PH_W'(1);
                    end
                end
                RX_PARITY: begin
                    if (bit_end) begin
                        s_d.ph      = '0;
                        s_d.perr    = (^s_q.sh) ^ rx_i;
                        s_d.all_low = s_q.all_low & ~rx_i;
                        s_d.st      = RX_STOP;
                    end else begin
                        s_d.ph = s_q.ph + PH_W'(1);
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        s_d.ph = '0;
                        if (two_stop_i && rx_i) begin
                            s_d.st = RX_STOP2;
                        end else begin
                            s_d.frm = ~rx_i;
                            s_d.brk = s_q.all_low & ~rx_i;
                            s_d.vld = 1'b1;
                            s_d.st  = rx_i ? RX_IDLE : RX_HOLD;
                        end
                    end else begin
                        s_d.ph = s_q.ph + PH_W'(1);
                    end
                end
                RX_STOP2: begin
                    if (bit_end) begin
                        s_d.ph  = '0;
                        s_d.frm = ~rx_i;
                        s_d.brk = 1'b0;
                        s_d.vld = 1'b1;
                        s_d.st  = rx_i ? RX_IDLE : RX_HOLD;
                    end else begin
                        s_d.ph = s_q.ph + PH_W'(1);
                    end
                end
                RX_HOLD: begin
                    if (rx_i) s_d.st = RX_IDLE;
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld_o      = s_q.vld;
    assign ent_o.data = s_q.sh;
    assign ent_o.brk  = s_q.brk;
    assign ent_o.frm  = s_q.frm;
    assign ent_o.par  = s_q.perr;
    assign ent_o.ovr  = 1'b0;

    // R6: a break character always carries the framing flag
    assert_break_has_framing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && ent_o.brk) |-> (ent_o.frm && ent_o.data == '0));

    // R4: parity flag only appears with parity enabled
    assert_parity_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && ent_o.par && $stable(par_en_i)) |-> par_en_i);

    // R3: a character is only delivered once per frame
    assert_single_delivery_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);
endmodule

// File: rtl/rx_queue.sv
module rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      push_i,
    input  rx_entry_t din_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      empty_o,
    output logic      full_o,
    output logic      half_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } q_state_t;

    q_state_t  s_d, s_q;
    rx_entry_t mem_q [DEPTH];
    logic      pop_ok, push_ok;

    always_comb begin
        empty_o = (s_q.cnt == '0);
        full_o  = (s_q.cnt == CW'(DEPTH));
        half_o  = (s_q.cnt >= CW'(DEPTH / 2));
        pop_ok  = pop_i && !empty_o && !clr_i;
        push_ok = push_i && !clr_i && (!full_o || pop_ok);
        s_d     = s_q;
        if (clr_i) begin
            s_d = '0;
        end else begin
            if (push_ok) s_d.wp = s_q.wp + AW'(1);
            if (pop_ok)  s_d.rp = s_q.rp + AW'(1);
            if (push_ok && !pop_ok)      s_d.cnt = s_q.cnt + CW'(1);
            else if (pop_ok && !push_ok) s_d.cnt = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wp] <= din_i;
    end

    assign head_o = mem_q[s_q.rp];

    // R8: occupancy never passes the depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    // R10: clear leaves the queue empty on the following cycle
    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> empty_o);

    // R9: a read on an empty queue changes nothing
    assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i && !clr_i) |=> (empty_o && $stable(s_q.rp)));

    // R9: a lone read lowers occupancy by one
    assert_pop_decrements_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o && !push_i && !clr_i) |=> (s_q.cnt == $past(s_q.cnt) - CW'(1)));
endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
    import uart_rx_pkg::*;
#(
    parameter int DIV_W      = 10,
    parameter int DATA_BITS  = 8,
    parameter int OVS        = 16,
    parameter int SYNC_STAGE = 2,
    parameter int DEPTH      = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             par_even_en,
    input  logic             stop_two,
    input  logic             q_clear,
    input  logic             rd_pop,
    output logic [15:0]      rd_word,
    output logic             rx_ready,
    output logic             q_empty,
    output logic             q_full,
    output logic             q_half
);
    logic      rx_s, tick;
    logic      fr_vld;
    rx_entry_t fr_ent, push_ent, head;
    logic      take, drop, push;
    logic      ovr_d, ovr_q;

    rx_line_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(rx_line), .sync_o(rx_s)
    );

    rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div_i(baud_div), .tick_o(tick)
    );

    rx_framer #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_s),
        .par_en_i(par_even_en), .two_stop_i(stop_two),
        .vld_o(fr_vld), .ent_o(fr_ent)
    );

    always_comb begin
        take         = rd_pop && !q_empty;
        drop         = fr_vld && q_full && !take && !q_clear;
        push         = fr_vld && !drop;
        push_ent     = fr_ent;
        push_ent.ovr = ovr_q;
        if (q_clear)   ovr_d = 1'b0;
        else if (drop) ovr_d = 1'b1;
        else if (push) ovr_d = 1'b0;
        else           ovr_d = ovr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= ovr_d;
    end

    rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .clr_i(q_clear), .push_i(push),
        .din_i(push_ent), .pop_i(rd_pop), .head_o(head),
        .empty_o(q_empty), .full_o(q_full), .half_o(q_half)
    );

    assign rx_ready = !q_empty;
    assign rd_word  = q_empty ? 16'h0000 : entry_to_word(head);

    // R7: a character arriving into a full, undrained queue arms the overrun flag
    assert_overrun_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_vld && q_full && !rd_pop && !q_clear) |=> ovr_q);

    // R10: clear cancels a pending overrun
    assert_clear_cancels_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_clear |=> !ovr_q);
endmodule

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic [9:0]  baud_div = 10'd4;
    logic        par_even_en = 1'b0;
    logic        stop_two = 1'b0;
    logic        q_clear = 1'b0;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_word;
    logic        rx_ready, q_empty, q_full, q_half;

    always #2 clk = ~clk;

    uart_rx_tagged dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_div(baud_div),
        .par_even_en(par_even_en), .stop_two(stop_two), .q_clear(q_clear),
        .rd_pop(rd_pop), .rd_word(rd_word), .rx_ready(rx_ready),
        .q_empty(q_empty), .q_full(q_full), .q_half(q_half)
    );

    int          vectors = 0;
    int          miscompares = 0;
    bit          settled = 1'b0;
    bit          done = 1'b0;
    bit          ovr_pend = 1'b0;
    logic [15:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // reference model: store with overrun tagging, drop when full
    task automatic model_push(input logic [15:0] w);
        if (exp_q.size() == 64) begin
            ovr_pend = 1'b1;
        end else begin
            exp_q.push_back(w | (ovr_pend ? 16'h1000 : 16'h0000));
            ovr_pend = 1'b0;
        end
    endtask

    // per-clock comparison of status and head against the model
    always @(negedge clk) begin
        if (settled && rst_n && !done) begin
            chk(q_empty == (exp_q.size() == 0), "R8", "empty", 32'(q_empty), 32'(exp_q.size() == 0));
            chk(rx_ready == (exp_q.size() != 0), "R8", "ready", 32'(rx_ready), 32'(exp_q.size() != 0));
            chk(q_full == (exp_q.size() == 64), "R8", "full", 32'(q_full), 32'(exp_q.size() == 64));
            chk(q_half == (exp_q.size() >= 32), "R8", "half", 32'(q_half), 32'(exp_q.size() >= 32));
            if (exp_q.size() != 0)
                chk(rd_word == exp_q[0], "R9", "head word", 32'(rd_word), 32'(exp_q[0]));
            else
                chk(rd_word == 16'h0000, "R9", "empty word", 32'(rd_word), 32'h0);
        end
    end

    task automatic line_bit(input logic b);
        rx_line = b;
        repeat (16 * int'(baud_div)) @(negedge clk);
    endtask

    // frame with configurable parity corruption and stop levels; hold_low extends a low line
    task automatic send_frame(input logic [7:0] d, input bit flip_par,
                              input logic stop1, input logic stop2,
                              input int hold_low, input bit expect_rx);
        logic        pbit;
        logic [15:0] w;
        settled = 1'b0;
        pbit = (^d) ^ flip_par;
        @(negedge clk);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        if (par_even_en) line_bit(pbit);
        line_bit(stop1);
        if (stop_two && stop1) line_bit(stop2);
        for (int i = 0; i < hold_low; i++) line_bit(1'b0);
        line_bit(1'b1);
        line_bit(1'b1);
        if (expect_rx) begin
            w = {8'h00, d};
            if (par_even_en && flip_par) w[13] = 1'b1;
            if (!stop1 || (stop_two && !stop2)) w[14] = 1'b1;
            if (d == 8'h00 && !stop1 && (!par_even_en || !pbit)) w[15] = 1'b1;
            model_push(w);
        end
        settled = 1'b1;
    endtask

    task automatic pop_one();
        @(negedge clk) rd_pop = 1'b1;
        @(posedge clk);
        if (exp_q.size() != 0) void'(exp_q.pop_front());
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic pop_check(input logic [15:0] expw, input string req);
        @(negedge clk);
        chk(rd_word == expw, req, "popped word", 32'(rd_word), 32'(expw));
        pop_one();
    endtask

    task automatic clear_q();
        @(negedge clk) q_clear = 1'b1;
        @(posedge clk);
        exp_q.delete();
        ovr_pend = 1'b0;
        @(negedge clk) q_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R8, R9)
        chk(q_empty && !rx_ready && !q_full && !q_half, "R8", "reset status",
            {28'h0, q_empty, rx_ready, q_full, q_half}, 32'h8);
        chk(rd_word == 16'h0000, "R9", "reset word", 32'(rd_word), 32'h0);
        settled = 1'b1;

        // R2: plain frames, LSB first
        send_frame(8'hA5, 0, 1, 1, 0, 1);
        send_frame(8'h3C, 0, 1, 1, 0, 1);
        send_frame(8'h01, 0, 1, 1, 0, 1);
        pop_check(16'h00A5, "R2");
        pop_check(16'h003C, "R2");
        pop_check(16'h0001, "R2");
        // R9: pop on empty is ignored
        pop_one();
        chk(q_empty, "R9", "empty after idle pop", 32'(q_empty), 32'h1);

        // R4: even parity
        par_even_en = 1'b1;
        send_frame(8'h37, 0, 1, 1, 0, 1);
        send_frame(8'h37, 1, 1, 1, 0, 1);
        pop_check(16'h0037, "R4");
        pop_check(16'h2037, "R4");
        par_even_en = 1'b0;

        // R5: framing on first stop, then two-stop mode
        send_frame(8'h55, 0, 0, 1, 0, 1);
        pop_check(16'h4055, "R5");
        stop_two = 1'b1;
        send_frame(8'h81, 0, 1, 0, 0, 1);
        send_frame(8'h7E, 0, 1, 1, 0, 1);
        pop_check(16'h4081, "R5");
        pop_check(16'h007E, "R5");
        stop_two = 1'b0;

        // R6: break held low, then a normal character
        send_frame(8'h00, 0, 0, 0, 3, 1);
        send_frame(8'h42, 0, 1, 1, 0, 1);
        pop_check(16'hC000, "R6");
        pop_check(16'h0042, "R6");
        par_even_en = 1'b1;
        send_frame(8'h00, 0, 0, 0, 2, 1);
        pop_check(16'hC000, "R6");
        par_even_en = 1'b0;

        // R3: short low glitch produces nothing
        @(negedge clk) rx_line = 1'b0;
        repeat (3 * 4) @(negedge clk);
        rx_line = 1'b1;
        repeat (1000) @(negedge clk);
        chk(q_empty, "R3", "glitch ignored", 32'(q_empty), 32'h1);

        // R1: stalled tick receives nothing
        baud_div = 10'd1;
        settled = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 12; i++) line_bit(i == 0 ? 1'b0 : 1'b1);
        chk(q_empty, "R1", "no rx at divisor 1", 32'(q_empty), 32'h1);
        baud_div = 10'd4;
        repeat (100) @(negedge clk);

        // R8, R7: fill, overflow, pop, overrun-tagged char
        baud_div = 10'd2;
        for (int i = 0; i < 64; i++) begin
            send_frame(8'(i), 0, 1, 1, 0, 1);
            if (i == 30) chk(!q_half, "R8", "half at 31", 32'(q_half), 32'h0);
            if (i == 31) chk(q_half, "R8", "half at 32", 32'(q_half), 32'h1);
        end
        chk(q_full, "R8", "full at 64", 32'(q_full), 32'h1);
        send_frame(8'hEE, 0, 1, 1, 0, 1);
        send_frame(8'hDD, 0, 1, 1, 0, 1);
        pop_check(16'h0000, "R8");
        send_frame(8'h99, 0, 1, 1, 0, 1);
        for (int i = 1; i < 64; i++) pop_check(16'(i), "R8");
        pop_check(16'h1099, "R7");
        chk(q_empty, "R8", "drained", 32'(q_empty), 32'h1);

        // R10: clear empties and cancels pending overrun
        for (int i = 0; i < 64; i++) send_frame(8'(i + 100), 0, 1, 1, 0, 1);
        send_frame(8'hEE, 0, 1, 1, 0, 1);
        clear_q();
        chk(q_empty && !q_full, "R10", "cleared", {30'h0, q_empty, q_full}, 32'h2);
        send_frame(8'h5A, 0, 1, 1, 0, 1);
        pop_check(16'h005A, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule